// File: doc/BRIEF.md
# Disk Sector Position Tracker

The tracker watches the single pulse line of a hard-sectored diskette drive. That line carries sixteen sector holes per revolution plus one extra index hole. The block separates the two kinds of hole with a timing window and keeps a count of the sector currently under the head. A revolution takes about 200 ms, so a new sector begins about every 12.5 ms. At the start of each sector the block gives a short sector-true pulse to the read/write logic. If the software has enabled interrupts, it also latches an interrupt request.

Every accepted hole edge starts a stretch period of about 300 µs, during which further edges are ignored. When the stretch of a sector hole ends, an index window of about 9.6 ms opens. A hole that arrives inside that window is the index hole, and it clears the count. The CPU reads a position byte: bit 0 is the sector-true flag (active low) and the sector number sits directly above it. All periods are given in clock cycles through parameters.

Top module: `dsk_sector_tracker`

## Requirements
- R1: After reset, sector_byte_o is 8'h01 (sector 0, flag inactive), and sector_true_o and irq_o are 0.
- R2: A hole whose rising edge falls inside the index window is taken as the index. The window opens STRETCH_CYC cycles after a sector hole is accepted and lasts WINDOW_CYC cycles. The index sets the count to 0 and produces no sector-true pulse and no interrupt. A hole that arrives after the window has closed is a sector hole.
- R3: Each sector hole, once the count is valid, drives sector_true_o high for exactly TRUE_CYC cycles. For the same cycles, bit 0 of sector_byte_o is 0; otherwise bit 0 is 1.
- R4: The first sector hole after an index reports sector 0, and each later sector hole adds one. After SECTORS-1 the count wraps to 0 without an index. The number appears in bits [4:1] of sector_byte_o, and bits [7:5] are 0.
- R5: Rising edges within STRETCH_CYC cycles of an accepted edge are ignored. They do not advance the count and do not give an extra sector-true pulse.
- R6: After reset or after the drive is enabled, the count is not valid until an index is seen. While it is not valid, sector holes give no sector-true pulse and no interrupt, and the byte stays 8'h01.
- R7: When the interrupt is enabled and the count is valid, each sector start sets irq_o. irq_o then holds until irq_ack_i, or until the interrupt is disabled. If a sector start and an acknowledge arrive in the same cycle, the start wins.
- R8: irq_en_set_i enables the interrupt and irq_en_clr_i disables it; the disable wins when both come together. Disabling also clears a pending request. With drive_on_i low, the block clears the enable, the request and the count, marks the count invalid, and ignores holes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hole_pulse_i | input | 1 | Raw index/sector hole pulse line, active high |
| drive_on_i | input | 1 | Drive enabled; low clears the tracker |
| irq_en_set_i | input | 1 | One-cycle strobe that enables the interrupt |
| irq_en_clr_i | input | 1 | One-cycle strobe that disables the interrupt |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| sector_byte_o | output | 8 | Position byte: bit 0 is the sector-true flag (active low), bits [4:1] the sector number |
| sector_true_o | output | 1 | Active-high pulse at the start of each sector |
| irq_o | output | 1 | Latched sector interrupt request |

## Verification
The bench places the index hole inside the window and places one stray hole just past the window. If the classification were wrong, the count would reset where it should advance, or advance where it should reset. A bounced edge checks the stretch: without it, the bench would see a doubled sector-true pulse and the numbering would slip. A run of eighteen sectors checks the wrap and the exact pulse length. Holes seen before the first index, or with the drive off, must give no pulse and no request; a design that forgot validity would raise them. The interrupt tests cover the latch, the acknowledge, the disable and a strobe that survives a drive-off; a design that let a stale enable live on would fire after the drive came back.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [1:0] {
    HOLE_NONE   = 2'd0,
    HOLE_SECTOR = 2'd1,
    HOLE_INDEX  = 2'd2
  } hole_e;

  localparam int unsigned POS_BYTE_W = 8;
endpackage

// File: rtl/dst_sync.sv
module dst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q[0] <= raw_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R5: a detected edge lasts one cycle only
  a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dst_classifier.sv
module dst_classifier
  import dst_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 600,
  parameter int unsigned WINDOW_CYC  = 19200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  drive_on_i,
  input  logic  rise_i,
  output hole_e hole_o
);
  localparam int unsigned ST_W = $clog2(STRETCH_CYC + 1);
  localparam int unsigned WN_W = $clog2(WINDOW_CYC + 1);

  logic [ST_W-1:0] st_q, st_d;
  logic [WN_W-1:0] win_q, win_d;
  logic            kind_q, kind_d;
  logic            accept;

  always_comb begin
    accept = drive_on_i && rise_i && (st_q == '0);
    hole_o = HOLE_NONE;
    if (accept) hole_o = (win_q != '0) ? HOLE_INDEX : HOLE_SECTOR;

    st_d   = st_q;
    win_d  = win_q;
    kind_d = kind_q;
    if (!drive_on_i) begin
      st_d   = '0;
      win_d  = '0;
      kind_d = 1'b0;
    end else if (accept) begin
      st_d   = ST_W'(STRETCH_CYC);
      win_d  = '0;
      kind_d = (win_q == '0);
    end else if (st_q != '0) begin
      st_d = st_q - ST_W'(1);
      if (st_q == ST_W'(1) && kind_q) win_d = WN_W'(WINDOW_CYC);
    end else if (win_q != '0) begin
      win_d = win_q - WN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      win_q  <= '0;
      kind_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      kind_q <= kind_d;
    end
  end

  // R5: an accepted hole is never followed by another in the next cycle
  a_r5_stretch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_o != HOLE_NONE) |=> (hole_o == HOLE_NONE));
  // R2: an index closes the window it fell into
  a_r2_index_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_o == HOLE_INDEX) |=> (win_q == '0));
  // R8: nothing is classified while the drive is off
  a_r8_off_no_hole: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_on_i |-> (hole_o == HOLE_NONE));
endmodule

// File: rtl/dst_position.sv
module dst_position
  import dst_pkg::*;
#(
  parameter int unsigned SECTORS  = 16,
  parameter int unsigned TRUE_CYC = 60
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  drive_on_i,
  input  hole_e                                 hole_i,
  output logic [((SECTORS>1)?$clog2(SECTORS):1)-1:0] sec_num_o,
  output logic                                  sector_true_o,
  output logic                                  start_o
);
  localparam int unsigned SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int unsigned TR_W  = $clog2(TRUE_CYC + 1);

  logic [SEC_W-1:0] cnt_q, cnt_d;
  logic [TR_W-1:0]  tr_q, tr_d;
  logic             valid_q, valid_d;
  logic             hold_q, hold_d;

  assign start_o = valid_q && (hole_i == HOLE_SECTOR);

  always_comb begin
    cnt_d   = cnt_q;
    tr_d    = tr_q;
    valid_d = valid_q;
    hold_d  = hold_q;
    if (!drive_on_i) begin
      cnt_d   = '0;
      tr_d    = '0;
      valid_d = 1'b0;
      hold_d  = 1'b0;
    end else begin
      if (hole_i == HOLE_INDEX) begin
        cnt_d   = '0;
        valid_d = 1'b1;
        hold_d  = 1'b1;
      end else if (start_o) begin
        if (hold_q)                                hold_d = 1'b0;
        else if (cnt_q == SEC_W'(SECTORS - 1))     cnt_d  = '0;
        else                                       cnt_d  = cnt_q + SEC_W'(1);
      end
      if (start_o)          tr_d = TR_W'(TRUE_CYC);
      else if (tr_q != '0)  tr_d = tr_q - TR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tr_q    <= '0;
      valid_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      tr_q    <= tr_d;
      valid_q <= valid_d;
      hold_q  <= hold_d;
    end
  end

  assign sec_num_o     = cnt_q;
  assign sector_true_o = (tr_q != '0);

  // R2: the index leaves the count at zero
  a_r2_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_i == HOLE_INDEX) |=> (sec_num_o == '0));
  // R3: a valid sector start raises sector-true next cycle
  a_r3_true_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> sector_true_o);
  // R6: no sector-true while the count is not valid
  a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !sector_true_o);
  // R4: the count stays inside the sector range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sec_num_o) < SECTORS));
endmodule

// File: rtl/dst_irq.sv
module dst_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_on_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic ack_i,
  input  logic start_i,
  output logic irq_o
);
  logic en_q, en_d;
  logic req_q, req_d;

  always_comb begin
    en_d  = en_q;
    req_d = req_q;
    if (!drive_on_i || en_clr_i) begin
      en_d  = 1'b0;
      req_d = 1'b0;
    end else begin
      if (en_set_i)            en_d  = 1'b1;
      if (start_i && en_q)     req_d = 1'b1;
      else if (ack_i)          req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      req_q <= req_d;
    end
  end

  assign irq_o = req_q;

  // R7: acknowledge without a fresh start drops the request
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !start_i) |=> !irq_o);
  // R7: a request holds until acknowledged or disabled
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && drive_on_i && !ack_i && !en_clr_i) |=> irq_o);
  // R8: disable strobe or drive off clears the request
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_i || !drive_on_i) |=> !irq_o);
endmodule

// File: rtl/dsk_sector_tracker.sv
module dsk_sector_tracker
  import dst_pkg::*;
#(
  parameter int unsigned SECTORS     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 600,
  parameter int unsigned WINDOW_CYC  = 19200,
  parameter int unsigned TRUE_CYC    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hole_pulse_i,
  input  logic       drive_on_i,
  input  logic       irq_en_set_i,
  input  logic       irq_en_clr_i,
  input  logic       irq_ack_i,
  output logic [7:0] sector_byte_o,
  output logic       sector_true_o,
  output logic       irq_o
);
  localparam int unsigned SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int unsigned PAD_W = POS_BYTE_W - 1 - SEC_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic             rise;
  hole_e            hole;
  logic [SEC_W-1:0] sec_num;
  logic             sec_true;
  logic             sec_start;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  dst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .raw_i  (hole_pulse_i),
    .rise_o (rise)
  );

  dst_classifier #(.STRETCH_CYC(STRETCH_CYC), .WINDOW_CYC(WINDOW_CYC)) u_class (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .drive_on_i (drive_on_i),
    .rise_i     (rise),
    .hole_o     (hole)
  );

  dst_position #(.SECTORS(SECTORS), .TRUE_CYC(TRUE_CYC)) u_pos (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .drive_on_i    (drive_on_i),
    .hole_i        (hole),
    .sec_num_o     (sec_num),
    .sector_true_o (sec_true),
    .start_o       (sec_start)
  );

  dst_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .drive_on_i (drive_on_i),
    .en_set_i   (irq_en_set_i),
    .en_clr_i   (irq_en_clr_i),
    .ack_i      (irq_ack_i),
    .start_i    (sec_start),
    .irq_o      (irq_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign sector_byte_o = {{PAD_W{1'b0}}, sec_num, ~sec_true};
    end else begin : g_nopad
      assign sector_byte_o = {sec_num, ~sec_true};
    end
  endgenerate
  assign sector_true_o = sec_true;

  // R3: the byte flag mirrors the pulse, active low
  a_r3_flag_matches: assert property (@(posedge clk) disable iff (!rst_n_int)
    sector_byte_o[0] != sector_true_o);
endmodule

// File: tb/tb_dsk_sector_tracker.sv
`timescale 1ns/1ps
module tb_dsk_sector_tracker;
  localparam int STRETCH = 8;
  localparam int WINDOW  = 40;
  localparam int TRUEC   = 5;
  localparam int NSEC    = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hole, drive_on, en_set, en_clr, ack;
  logic [7:0] sbyte;
  logic       strue, irq;

  always #2 clk = ~clk;

  dsk_sector_tracker #(
    .SECTORS(NSEC), .SYNC_STAGES(2), .STRETCH_CYC(STRETCH),
    .WINDOW_CYC(WINDOW), .TRUE_CYC(TRUEC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hole_pulse_i(hole), .drive_on_i(drive_on),
    .irq_en_set_i(en_set), .irq_en_clr_i(en_clr), .irq_ack_i(ack),
    .sector_byte_o(sbyte), .sector_true_o(strue), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  bit m_valid = 0;
  bit m_hold = 0;
  int m_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int idle_byte(input int c);
    return (c << 1) | 1;
  endfunction

  // driver: pulse the line, update the model, push expected sector number
  task automatic sector_hole(input int gap);
    if (m_valid && drive_on) begin
      if (m_hold) m_hold = 0;
      else m_cnt = (m_cnt + 1) % NSEC;
      exp_q.push_back(m_cnt);
    end
    @(negedge clk) hole = 1'b1;
    repeat (3) @(negedge clk);
    hole = 1'b0;
    repeat (gap - 3) @(negedge clk);
  endtask

  task automatic bounce_hole(input int gap);
    if (m_valid) begin
      if (m_hold) m_hold = 0;
      else m_cnt = (m_cnt + 1) % NSEC;
      exp_q.push_back(m_cnt);
    end
    @(negedge clk) hole = 1'b1;
    repeat (2) @(negedge clk); hole = 1'b0;
    repeat (2) @(negedge clk); hole = 1'b1;
    repeat (2) @(negedge clk); hole = 1'b0;
    repeat (gap - 6) @(negedge clk);
  endtask

  task automatic index_hole(input int gap);
    if (drive_on) begin m_valid = 1; m_cnt = 0; m_hold = 1; end
    @(negedge clk) hole = 1'b1;
    repeat (3) @(negedge clk);
    hole = 1'b0;
    repeat (gap - 3) @(negedge clk);
  endtask

  task automatic strobe(input bit s, input bit c);
    @(negedge clk); en_set = s; en_clr = c;
    @(negedge clk); en_set = 1'b0; en_clr = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R7 ack clears irq", int'(irq), 0);
  endtask

  // monitor: pops the scoreboard on every sector-true rising edge
  initial begin
    bit prev = 1'b0;
    int len = 0;
    forever begin
      @(negedge clk);
      if (strue && !prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected sector-true", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(sbyte) == (e << 1), "R4 sector number in byte", int'(sbyte), e << 1);
        end
        len = 1;
      end else if (strue) begin
        len++;
      end else if (prev) begin
        check(len == TRUEC, "R3 sector-true length", len, TRUEC);
      end
      prev = strue;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1 actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    hole = 0; drive_on = 0; en_set = 0; en_clr = 0; ack = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sbyte == 8'h01, "R1 reset byte", int'(sbyte), 1);
    check(strue == 1'b0, "R1 reset sector-true", int'(strue), 0);
    check(irq == 1'b0, "R1 reset irq", int'(irq), 0);

    drive_on = 1'b1;
    repeat (4) @(negedge clk);
    strobe(1, 0);
    // R6: holes before the first index are not reported
    sector_hole(80);
    check(irq == 1'b0, "R6 no irq before index", int'(irq), 0);
    check(sbyte == 8'h01, "R6 byte before index", int'(sbyte), 1);
    sector_hole(25);
    // R2: index inside the window resets the count
    index_hole(55);
    check(sbyte == 8'h01, "R2 index gives sector 0", int'(sbyte), 1);
    check(irq == 1'b0, "R2 index raises no irq", int'(irq), 0);

    // R4: eighteen sectors, wrap past 15
    for (int i = 0; i < 18; i++) begin
      if (i == 3) bounce_hole(80);   // R5 bounce
      else sector_hole(80);
      check(irq == 1'b1, "R7 sector start sets irq", int'(irq), 1);
      check(int'(sbyte) == idle_byte(m_cnt), "R4 idle byte", int'(sbyte), idle_byte(m_cnt));
      if (i == 5) begin
        repeat (30) @(negedge clk);
        check(irq == 1'b1, "R7 irq stays latched", int'(irq), 1);
      end
      do_ack();
    end

    // R2: hole after the window closes counts as a sector
    sector_hole(60);
    sector_hole(80);
    check(int'(sbyte) == idle_byte(m_cnt), "R2 late hole is a sector", int'(sbyte), idle_byte(m_cnt));
    do_ack();

    // R8: disable strobe stops interrupts, count still runs
    strobe(0, 1);
    sector_hole(80);
    check(irq == 1'b0, "R8 disabled no irq", int'(irq), 0);
    // R8: disable clears a pending request
    strobe(1, 0);
    sector_hole(80);
    check(irq == 1'b1, "R7 re-enabled irq", int'(irq), 1);
    strobe(0, 1);
    check(irq == 1'b0, "R8 disable clears pending", int'(irq), 0);
    // R8: set and clear together leaves disabled
    strobe(1, 1);
    sector_hole(80);
    check(irq == 1'b0, "R8 clear wins over set", int'(irq), 0);

    // R8: drive off clears everything and ignores holes
    strobe(1, 0);
    sector_hole(80);
    check(irq == 1'b1, "R7 irq before drive off", int'(irq), 1);
    drive_on = 1'b0;
    m_valid = 0; m_cnt = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R8 drive off clears irq", int'(irq), 0);
    check(sbyte == 8'h01, "R8 drive off clears count", int'(sbyte), 1);
    sector_hole(30);
    index_hole(60);
    check(sbyte == 8'h01, "R8 holes ignored while off", int'(sbyte), 1);
    drive_on = 1'b1;
    repeat (4) @(negedge clk);
    sector_hole(25);
    check(sbyte == 8'h01, "R6 invalid after re-enable", int'(sbyte), 1);
    index_hole(55);
    sector_hole(80);
    check(irq == 1'b0, "R8 enable lost on drive off", int'(irq), 0);
    check(sbyte == 8'h01, "R4 first sector after index is 0", int'(sbyte), 1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all sector-true pulses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule